// File: doc/BRIEF.md
# Pause Quantum Transmit Hold Timer

This block holds off a full-duplex Ethernet MAC transmitter after a flow-control pause request arrives. A receive-side parser, outside the block, delivers a one-cycle event when a pause frame has been validated, together with the pause quantum that the frame carries. When receive pause is enabled and the link runs in full duplex, the block loads the quantum into a down-counter. From then on it keeps new frames from starting until the counter has run down to zero. A frame that is already leaving the MAC is never cut short: the counter only runs while the transmitter reports that it is idle.

One quantum equals 512 bit times. A bit-time tick comes from the line-rate logic, and an internal prescaler divides it down. A test-mode input makes the counter step on every clock instead, so the timer can be exercised quickly. Each new valid pause frame reloads the counter, even when a pause is still running. A zero quantum therefore ends a pause at once. The block raises a one-cycle interrupt pulse when the counter steps down to zero and when a zero-quantum frame arrives. It also forwards every pause-received event as a pulse, in half duplex too, so that the interrupt logic still sees it. The current count can be read back.

Top module: `pause_hold_timer`

## Requirements
- R1: When a pause event arrives while receive pause is enabled and full duplex is selected, the count reads the frame's quantum on the next clock, whether or not a pause was already running.
- R2: When the pause event arrives with full duplex off or with receive pause disabled, the count is not loaded. Apart from loading, the count never increases.
- R3: `pause_seen_o` pulses high for one cycle, one clock after every pause event, whatever the duplex and enable settings are.
- R4: `tx_inhibit_o` is high exactly while the count is non-zero and `tx_busy_i` is low. It is never high while `tx_busy_i` is high.
- R5: While `tx_busy_i` is high, the count holds its value.
- R6: With test mode off and the transmitter idle, the count steps down by one after every 512 bit-time ticks. A load restarts this 512-tick interval from zero.
- R7: With test mode on and the transmitter idle, the count steps down by one on every clock while it is non-zero.
- R8: `expire_irq_o` pulses for one cycle on the same clock edge on which a decrement takes the count from 1 to 0. A reload on that edge suppresses the pulse.
- R9: A pause event with a zero quantum pulses `expire_irq_o` on the next clock, in any duplex setting. When the event loads, it clears the count at once and releases the inhibit.
- R10: After reset, the count is zero and `tx_inhibit_o`, `expire_irq_o` and `pause_seen_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pause_valid_i | input | 1 | One-cycle event: a validated pause frame was received |
| pause_quanta_i | input | QUANTA_W | Pause quantum of that frame |
| rx_pause_en_i | input | 1 | Honour received pause frames |
| full_duplex_i | input | 1 | Link runs in full duplex |
| tx_busy_i | input | 1 | High while a frame is being transmitted |
| test_mode_i | input | 1 | Decrement on every clock instead of every 512 bit times |
| bit_tick_i | input | 1 | One pulse per bit time |
| tx_inhibit_o | output | 1 | Blocks the start of a new frame |
| expire_irq_o | output | 1 | Pulse when the pause ends by count-down or by a zero quantum |
| pause_seen_o | output | 1 | Pulse forwarded for every pause event |
| pause_count_o | output | QUANTA_W | Current pause count |

## Verification
On every cycle, the assertions check the load and no-load rules, the rule that the count never increases except on a load, the freeze while the transmitter is busy, the relation between the inhibit and the busy input, the one-per-clock decrement in test mode, and the causes of each interrupt pulse. The 512-tick spacing of decrements in normal mode and the prescaler restart on a reload span hundreds of cycles, so only the bench scenarios show them. The bench also covers the exact cycle of each interrupt and the order of events across a reload while a pause is running.

// File: rtl/pht_pkg.sv
// Shared defaults for the pause hold timer.
// Assumes: a quantum is a fixed number of bit times and the quantum field is 16 bits wide.
package pht_pkg;
    parameter int unsigned PHT_QUANTA_W      = 16;
    parameter int unsigned PHT_BITS_PER_QNTM = 512;

    // Which event produced an interrupt pulse (debug visibility only)
    typedef enum logic [1:0] {
        PHT_IRQ_NONE   = 2'd0,
        PHT_IRQ_EXPIRE = 2'd1,
        PHT_IRQ_ZERO   = 2'd2
    } pht_irq_src_e;
endpackage

// File: rtl/pht_prescaler.sv
// Divides bit-time ticks down to one decrement step per quantum.
// A fast input bypasses the divider, giving one step per clock.
// Assumes: clear_i has priority and restarts the interval from zero;
// the divider holds its value while run_i is low.
module pht_prescaler #(
    parameter int unsigned DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    input  logic fast_i,
    output logic step_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_q;

            // Count bit ticks while the timer runs; wrap at the last tick of a quantum
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i) begin
                    pre_q <= '0;
                end else if (run_i && tick_i && !fast_i) begin
                    pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
                end
            end

            // Step on the wrapping tick, or on every clock in fast mode
            always_comb begin
                step_o = run_i && (fast_i || (tick_i && (pre_q == LAST)));
            end
        end else begin : g_nodiv
            logic unused_in;
            // Divider of one: every tick is a step
            always_comb begin
                unused_in = clear_i ^ clk ^ rst_n;
                step_o    = run_i && (fast_i || tick_i);
            end
        end
    endgenerate
endmodule

// File: rtl/pht_counter.sv
// Holds the pause count: loads a quantum, otherwise steps down toward zero.
// Assumes: a load wins over a step on the same edge; a step only arrives while non-zero.
module pht_counter #(
    parameter int unsigned QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [QUANTA_W-1:0] quanta_i,
    input  logic                step_i,
    output logic [QUANTA_W-1:0] count_o,
    output logic                nonzero_o,
    output logic                expire_o
);
    localparam logic [QUANTA_W-1:0] ONE = QUANTA_W'(1);

    logic [QUANTA_W-1:0] count_q;

    // Load on a new pause, otherwise decrement on a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= quanta_i;
        end else if (step_i && (count_q != '0)) begin
            count_q <= count_q - ONE;
        end
    end

    // Flags for the top level and the interrupt logic
    always_comb begin
        count_o   = count_q;
        nonzero_o = (count_q != '0);
        expire_o  = step_i && !load_i && (count_q == ONE);
    end
endmodule

// File: rtl/pht_irq.sv
// Registers the one-cycle interrupt and pause-seen pulses.
// Assumes: the inputs are single-cycle events; the outputs follow them by one clock.
module pht_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_evt_i,
    input  logic zero_quanta_i,
    input  logic expire_i,
    output logic irq_o,
    output logic seen_o
);
    import pht_pkg::*;

    pht_irq_src_e src_d;

    // Classify the interrupt cause
    always_comb begin
        if (pause_evt_i && zero_quanta_i) begin
            src_d = PHT_IRQ_ZERO;
        end else if (expire_i) begin
            src_d = PHT_IRQ_EXPIRE;
        end else begin
            src_d = PHT_IRQ_NONE;
        end
    end

    // Register both pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            seen_o <= 1'b0;
        end else begin
            irq_o  <= (src_d != PHT_IRQ_NONE);
            seen_o <= pause_evt_i;
        end
    end
endmodule

// File: rtl/pause_hold_timer.sv
// Top level of the pause hold timer.
// Loads the received quantum (full duplex with pause enabled only), counts it
// down in quanta of bit times once the transmitter is idle, and inhibits new frame starts
// while the count is non-zero. A frame that is already being sent is never blocked.
// Assumes: pause_valid_i is a one-cycle event from an upstream validator.
module pause_hold_timer #(
    parameter int unsigned QUANTA_W      = pht_pkg::PHT_QUANTA_W,
    parameter int unsigned BITS_PER_QNTM = pht_pkg::PHT_BITS_PER_QNTM
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pause_valid_i,
    input  logic [QUANTA_W-1:0] pause_quanta_i,
    input  logic                rx_pause_en_i,
    input  logic                full_duplex_i,
    input  logic                tx_busy_i,
    input  logic                test_mode_i,
    input  logic                bit_tick_i,
    output logic                tx_inhibit_o,
    output logic                expire_irq_o,
    output logic                pause_seen_o,
    output logic [QUANTA_W-1:0] pause_count_o
);
    logic load;
    logic run;
    logic step;
    logic nonzero;
    logic expire;
    logic zero_q;

    // Qualify the load and the running condition
    always_comb begin
        load         = pause_valid_i && rx_pause_en_i && full_duplex_i;
        zero_q       = (pause_quanta_i == '0);
        run          = nonzero && !tx_busy_i;
        tx_inhibit_o = run;
    end

    pht_prescaler #(.DIV(BITS_PER_QNTM)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load),
        .run_i   (run),
        .tick_i  (bit_tick_i),
        .fast_i  (test_mode_i),
        .step_o  (step)
    );

    pht_counter #(.QUANTA_W(QUANTA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .quanta_i  (pause_quanta_i),
        .step_i    (step),
        .count_o   (pause_count_o),
        .nonzero_o (nonzero),
        .expire_o  (expire)
    );

    pht_irq u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pause_evt_i   (pause_valid_i),
        .zero_quanta_i (zero_q),
        .expire_i      (expire),
        .irq_o         (expire_irq_o),
        .seen_o        (pause_seen_o)
    );
endmodule

// File: rtl/pht_checker.sv
// Property checker for the pause hold timer, attached through bind.
// Assumes: the same clock and synchronous active-low reset as the design.
module pht_checker #(
    parameter int unsigned QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pause_valid_i,
    input logic [QUANTA_W-1:0] pause_quanta_i,
    input logic                rx_pause_en_i,
    input logic                full_duplex_i,
    input logic                tx_busy_i,
    input logic                test_mode_i,
    input logic                tx_inhibit_o,
    input logic                expire_irq_o,
    input logic                pause_seen_o,
    input logic [QUANTA_W-1:0] pause_count_o
);
    localparam logic [QUANTA_W-1:0] ONE = QUANTA_W'(1);

    logic ld;
    always_comb ld = pause_valid_i && rx_pause_en_i && full_duplex_i;

    AST_LOAD_QUANTA: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> pause_count_o == $past(pause_quanta_i)); // R1

    AST_NO_RISE_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> pause_count_o <= $past(pause_count_o)); // R2

    AST_SEEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid_i |=> pause_seen_o); // R3

    AST_NO_INHIBIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy_i |-> !tx_inhibit_o); // R4

    AST_INHIBIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy_i && pause_count_o != '0) |-> tx_inhibit_o); // R4

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy_i && !ld) |=> $stable(pause_count_o)); // R5

    AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode_i && !tx_busy_i && !ld && pause_count_o != '0)
        |=> pause_count_o == $past(pause_count_o) - ONE); // R7

    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode_i && !tx_busy_i && !ld && pause_count_o == ONE) |=> expire_irq_o); // R8

    AST_ZERO_QUANTA_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid_i && pause_quanta_i == '0) |=> expire_irq_o); // R9

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        expire_irq_o |-> ($past(pause_count_o) == ONE
                          || ($past(pause_valid_i) && $past(pause_quanta_i) == '0))); // R8
endmodule

bind pause_hold_timer pht_checker #(.QUANTA_W(QUANTA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pause_valid_i  (pause_valid_i),
    .pause_quanta_i (pause_quanta_i),
    .rx_pause_en_i  (rx_pause_en_i),
    .full_duplex_i  (full_duplex_i),
    .tx_busy_i      (tx_busy_i),
    .test_mode_i    (test_mode_i),
    .tx_inhibit_o   (tx_inhibit_o),
    .expire_irq_o   (expire_irq_o),
    .pause_seen_o   (pause_seen_o),
    .pause_count_o  (pause_count_o)
);

// File: tb/sim_pause_hold_timer.sv
module sim_pause_hold_timer;
    localparam int QW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pv = 1'b0;
    logic [QW-1:0] pq = '0;
    logic          en = 1'b1;
    logic          fd = 1'b1;
    logic          busy = 1'b0;
    logic          tm = 1'b1;
    logic          tick = 1'b1;
    logic          inh;
    logic          irq;
    logic          seen;
    logic [QW-1:0] cnt;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    int irq_q[$];   // scoreboard: cycles at which an interrupt pulse is expected

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    pause_hold_timer u0 (
        .clk(clk), .rst_n(rst_n), .pause_valid_i(pv), .pause_quanta_i(pq),
        .rx_pause_en_i(en), .full_duplex_i(fd), .tx_busy_i(busy),
        .test_mode_i(tm), .bit_tick_i(tick), .tx_inhibit_o(inh),
        .expire_irq_o(irq), .pause_seen_o(seen), .pause_count_o(cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: one-cycle pause event; returns at the negedge where its effect is visible
    task automatic send_pause(input int q);
        pv = 1'b1;
        pq = QW'(q);
        @(negedge clk);
        pv = 1'b0;
        pq = '0;
    endtask

    // Monitor: every interrupt pulse must match the front of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && irq) begin
            checks++;
            if (irq_q.size() == 0) begin
                fails++;
                $display("FAIL R8/R9: actual unexpected irq at %0d expected none", cyc);
            end else begin
                int e;
                e = irq_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R8/R9: actual irq at %0d expected %0d", cyc, e);
                end
            end
        end
    end

    initial begin
        int c0;
        wait_n(3);
        rst_n = 1'b1;
        check("R10 count", int'(cnt), 0);
        check("R10 inhibit", int'(inh), 0);
        check("R10 irq", int'(irq), 0);
        check("R10 seen", int'(seen), 0);

        // Test mode load, then reload while active
        @(negedge clk);
        send_pause(5);
        check("R1 load", int'(cnt), 5);
        check("R4 inhibit on", int'(inh), 1);
        check("R3 seen", int'(seen), 1);
        wait_n(2);
        check("R7 fast step", int'(cnt), 3);
        send_pause(4);
        c0 = cyc;
        check("R1 reload while active", int'(cnt), 4);
        irq_q.push_back(c0 + 4);
        wait_n(4);
        check("R8 count zero", int'(cnt), 0);
        check("R4 inhibit off", int'(inh), 0);

        // Busy transmitter: count frozen, no inhibit
        busy = 1'b1;
        send_pause(3);
        check("R1 load busy", int'(cnt), 3);
        check("R4 no inhibit busy", int'(inh), 0);
        wait_n(3);
        check("R5 hold busy", int'(cnt), 3);
        busy = 1'b0;
        #1;
        check("R4 inhibit idle", int'(inh), 1);
        irq_q.push_back(cyc + 3);
        wait_n(1);
        check("R7 step after busy", int'(cnt), 2);
        wait_n(2);
        check("R8 done", int'(cnt), 0);

        // Half duplex and disabled receive pause
        fd = 1'b0;
        send_pause(7);
        check("R2 half duplex no load", int'(cnt), 0);
        check("R3 seen half duplex", int'(seen), 1);
        check("R2 inhibit half duplex", int'(inh), 0);
        fd = 1'b1; en = 1'b0;
        send_pause(7);
        check("R2 disabled no load", int'(cnt), 0);
        en = 1'b1;

        // Zero quantum clears a running pause; also interrupts in half duplex
        send_pause(6);
        check("R1 load six", int'(cnt), 6);
        irq_q.push_back(cyc + 1);
        send_pause(0);
        check("R9 zero clears", int'(cnt), 0);
        check("R9 inhibit released", int'(inh), 0);
        wait_n(2);
        fd = 1'b0;
        irq_q.push_back(cyc + 1);
        send_pause(0);
        check("R9 zero half duplex count", int'(cnt), 0);
        fd = 1'b1;
        wait_n(2);

        // Normal mode: 512 ticks per step, prescaler restarts on load
        tm = 1'b0;
        send_pause(2);
        c0 = cyc;
        wait_n(511);
        check("R6 before 512", int'(cnt), 2);
        wait_n(1);
        check("R6 at 512", int'(cnt), 1);
        wait_n(300);
        send_pause(1);
        c0 = cyc;
        irq_q.push_back(c0 + 512);
        wait_n(511);
        check("R6 prescaler restart", int'(cnt), 1);
        wait_n(1);
        check("R6 expire", int'(cnt), 0);
        wait_n(4);
        check("R8 all irqs seen", irq_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule